// File: doc/BRIEF.md
# Scalar FP64 Minimum Unit

This unit picks the smaller of two IEEE-754 double-precision values, a destination value and a source value, and follows a fixed, deliberately asymmetric rule set for special values. Whenever either input is any NaN, or both inputs are zeros of any sign, the unit returns the source operand unchanged. A signalling NaN in the source is passed through bit for bit and is not quieted. This behaviour departs from IEEE minNum.

The destination arrives as a 128-bit register image. Only the low 64 bits take part in the comparison, and only those bits are replaced by the result. The upper half passes through untouched. The unit also reports two status flags: invalid, for any NaN input, and denormal, for any subnormal input. Inputs are sampled on a cycle in which `in_valid` is high. The result and the flags are registered and appear one clock later together with `out_valid`.

Top module: `fp64_min_unit`

## Requirements
- R1: Bits 127:64 of `res_o` equal bits 127:64 of `dst_i` as sampled on the accepted cycle.
- R2: When both operands are zero (exponent and fraction all zero, either sign), the low result is the source operand, including its sign bit.
- R3: When the destination is an SNaN (exponent all ones, fraction nonzero, fraction bit 51 clear), the low result is the source operand.
- R4: When the source is an SNaN, the low result equals the source bit for bit, and fraction bit 51 stays clear.
- R5: When exactly one operand is a NaN of either kind, the low result is the source operand, whether the source is the NaN or an ordinary number.
- R6: Otherwise the low result is the destination if it is strictly less than the source, and the source if it is not. Any negative value is below any positive value. Two negative values compare by reversed magnitude. Infinities are ordered like finite values.
- R7: `inv_o` is 1 when either operand is a NaN, QNaN included, and 0 otherwise.
- R8: `den_o` is 1 when either operand has a zero exponent and a nonzero fraction, and 0 otherwise.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. A synchronous reset clears it. The outputs hold their values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are sampled on this cycle |
| dst_i | input | 128 | Destination register image; the low 64 bits are the first operand |
| src_i | input | 64 | Source operand |
| out_valid | output | 1 | Result registered from the previous accepted cycle |
| res_o | output | 128 | Destination image with its low half replaced by the minimum |
| inv_o | output | 1 | Invalid flag: an operand was a NaN |
| den_o | output | 1 | Denormal flag: an operand was subnormal |

## Verification
The embedded assertions check on every cycle that the valid pipeline has a latency of one, that the upper half passes through, and that the outputs hold when no input is accepted. They also check that any NaN or double-zero input selects the source, that an SNaN source keeps its quiet bit clear, and that the flags agree with the registered classification.

Only the bench scenarios can show that the ordered comparison is correct. That covers values of mixed sign, two negatives, infinities, and cases where the two magnitudes differ only in their low bits. The bench compares against its own model over directed corner cases and seeded random values that are biased toward special encodings.

// File: rtl/fp64_min_pkg.sv
package fp64_min_pkg;
  localparam int EXP_W = 11;
  localparam int FRC_W = 52;
  localparam int FP_W  = 1 + EXP_W + FRC_W;

  typedef struct packed {
    logic is_zero;
    logic is_den;
    logic is_inf;
    logic is_qnan;
    logic is_snan;
  } fp_class_t;

  function automatic fp_class_t classify(input logic [FP_W-1:0] v);
    fp_class_t c;
    logic [EXP_W-1:0] e;
    logic [FRC_W-1:0] f;
    e = v[FP_W-2 -: EXP_W];
    f = v[FRC_W-1:0];
    c.is_zero = (e == '0) && (f == '0);
    c.is_den  = (e == '0) && (f != '0);
    c.is_inf  = (e == '1) && (f == '0);
    c.is_qnan = (e == '1) && f[FRC_W-1];
    c.is_snan = (e == '1) && !f[FRC_W-1] && (f != '0);
    return c;
  endfunction

  // strict a < b on sign-magnitude encodings; NaNs are excluded by caller
  function automatic logic ordered_lt(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
    logic [FP_W-2:0] ma, mb;
    ma = a[FP_W-2:0];
    mb = b[FP_W-2:0];
    if (a[FP_W-1] != b[FP_W-1]) return a[FP_W-1];
    else if (a[FP_W-1])         return ma > mb;
    else                        return ma < mb;
  endfunction
endpackage

// File: rtl/fp64_classifier.sv
module fp64_classifier
  import fp64_min_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output fp_class_t       cls_o
);
  assign cls_o = classify(val_i);
endmodule

// File: rtl/fp64_min_select.sv
module fp64_min_select
  import fp64_min_pkg::*;
(
  input  logic [FP_W-1:0] dst_i,
  input  logic [FP_W-1:0] src_i,
  input  fp_class_t       dcls_i,
  input  fp_class_t       scls_i,
  output logic [FP_W-1:0] min_o,
  output logic            take_src_forced_o,
  output logic            nan_seen_o,
  output logic            den_seen_o
);
  logic dst_nan, src_nan, both_zero, dst_lt;

  assign dst_nan   = dcls_i.is_qnan | dcls_i.is_snan;
  assign src_nan   = scls_i.is_qnan | scls_i.is_snan;
  assign both_zero = dcls_i.is_zero & scls_i.is_zero;
  assign dst_lt    = ordered_lt(dst_i, src_i);

  assign take_src_forced_o = both_zero | dst_nan | src_nan;
  assign nan_seen_o        = dst_nan | src_nan;
  assign den_seen_o        = dcls_i.is_den | scls_i.is_den;

  always_comb begin
    if (take_src_forced_o) min_o = src_i;
    else if (dst_lt)       min_o = dst_i;
    else                   min_o = src_i;
  end
endmodule

// File: rtl/fp64_min_unit.sv
module fp64_min_unit
  import fp64_min_pkg::*;
#(
  parameter int REG_W = 2 * FP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [REG_W-1:0] dst_i,
  input  logic [FP_W-1:0]  src_i,
  output logic             out_valid,
  output logic [REG_W-1:0] res_o,
  output logic             inv_o,
  output logic             den_o
);
  localparam int HI_W = REG_W - FP_W;

  fp_class_t       dcls, scls;
  logic [FP_W-1:0] min_w;
  logic            forced_src, nan_seen, den_seen;

  fp64_classifier u_cls_d (.val_i(dst_i[FP_W-1:0]), .cls_o(dcls));
  fp64_classifier u_cls_s (.val_i(src_i),           .cls_o(scls));

  fp64_min_select u_sel (
    .dst_i(dst_i[FP_W-1:0]), .src_i(src_i),
    .dcls_i(dcls), .scls_i(scls),
    .min_o(min_w), .take_src_forced_o(forced_src),
    .nan_seen_o(nan_seen), .den_seen_o(den_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_o <= {dst_i[REG_W-1:FP_W], min_w};
      inv_o <= nan_seen;
      den_o <= den_seen;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (out_valid == $past(in_valid)));
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(in_valid)) |-> ($stable(res_o) && $stable(inv_o) && $stable(den_o)));
  // R1
  upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid)) |-> (res_o[REG_W-1 -: HI_W] == $past(dst_i[REG_W-1:FP_W])));
  // R2 R3 R5
  forced_source_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid) && $past(forced_src)) |-> (res_o[FP_W-1:0] == $past(src_i)));
  // R4
  snan_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid) && $past(scls.is_snan)) |-> (res_o[FRC_W-1] == 1'b0));
  // R7
  inv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid)) |-> (inv_o == $past(dcls.is_qnan | dcls.is_snan | scls.is_qnan | scls.is_snan)));
  // R8
  den_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid)) |-> (den_o == $past(dcls.is_den | scls.is_den)));
endmodule

// File: tb/test_fp64_min_unit.sv
module test_fp64_min_unit;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [127:0] dst_i = '0;
  logic [63:0]  src_i = '0;
  logic out_valid, inv_o, den_o;
  logic [127:0] res_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp64_min_unit i_fp64_min_unit (.clk, .rst, .in_valid, .dst_i, .src_i,
    .out_valid, .res_o, .inv_o, .den_o);

  function automatic bit nan_of(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction
  function automatic bit zero_of(input logic [63:0] v);
    return v[62:0] == 0;
  endfunction
  function automatic bit den_of(input logic [63:0] v);
    return (v[62:52] == 0) && (v[51:0] != 0);
  endfunction
  // map to an unsigned key whose order follows the real-number order
  function automatic logic [63:0] key_of(input logic [63:0] v);
    return v[63] ? ~v : {1'b1, v[62:0]};
  endfunction
  function automatic logic [63:0] model_min(input logic [63:0] d, input logic [63:0] s);
    if (nan_of(d) || nan_of(s) || (zero_of(d) && zero_of(s))) return s;
    return (key_of(d) < key_of(s)) ? d : s;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] d, input logic [63:0] s);
    logic [63:0] e;
    @(negedge clk);
    dst_i = d; src_i = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    e = model_min(d[63:0], s);
    check("R9 out_valid", {127'b0, out_valid}, 128'd1);
    check("R1 upper", {64'b0, res_o[127:64]}, {64'b0, d[127:64]});
    check("R2-R6 low", {64'b0, res_o[63:0]}, {64'b0, e});
    check("R7 inv", {127'b0, inv_o}, {127'b0, nan_of(d[63:0]) | nan_of(s)});
    check("R8 den", {127'b0, den_o}, {127'b0, den_of(d[63:0]) | den_of(s)});
  endtask

  function automatic logic [63:0] rnd_val();
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 8)
      0: v[62:52] = 0;
      1: v[62:52] = 11'h7FF;
      2: v[62:0] = 0;
      3: begin v[62:52] = 11'h7FF; v[51:0] = 0; end
      default: ;
    endcase
    return v;
  endfunction

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SN = 64'h7FF0_0000_0000_0001, QN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] ONE = 64'h3FF0_0000_0000_0000, MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] TWO = 64'h4000_0000_0000_0000, MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] DEN = 64'h0000_0000_0000_0003;
  localparam logic [63:0] HI = 64'hDEAD_BEEF_0123_4567;

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 reset", {127'b0, out_valid}, 128'd0);
    rst = 0;
    // R2 zeros of any sign pick source
    run({HI, PZ}, NZ);
    run({HI, NZ}, PZ);
    // R3 destination SNaN
    run({HI, SN}, ONE);
    // R4 source SNaN kept unquieted
    run({HI, ONE}, SN);
    check("R4 quiet bit", {127'b0, res_o[51]}, 128'd0);
    // R5 one QNaN
    run({HI, QN}, MTWO);
    run({HI, MTWO}, QN);
    // R6 ordering
    run({HI, MONE}, ONE);
    run({HI, MTWO}, MONE);
    run({HI, MONE}, MTWO);
    run({HI, TWO}, ONE);
    run({HI, NINF}, MTWO);
    run({HI, TWO}, PINF);
    run({HI, ONE}, ONE + 64'd1);
    // R8 denormal
    run({HI, DEN}, ONE);
    // R9 hold while idle
    repeat (2) @(negedge clk);
    check("R9 idle valid", {127'b0, out_valid}, 128'd0);
    check("R9 hold", {64'b0, res_o[63:0]}, {64'b0, DEN});
    for (int i = 0; i < 400; i++)
      run({$urandom, $urandom, rnd_val()}, rnd_val());
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule